// File: doc/BRIEF.md
# Parallel Flash Command Decoder

This block sits behind the host bus of a NOR-style parallel flash device. The bus has already been brought into the device clock domain, so each host write shows up as a one-cycle strobe with an address and a data byte. The block decodes these writes as commands. Some commands take effect at once. Others wait for a second cycle that either confirms them or supplies the target data.

The command set covers several jobs:
- choosing what a read returns: the array, identification codes, a small query table, or the status byte;
- clearing errors;
- programming a byte;
- erasing a block;
- suspending and resuming a running job;
- setting or clearing per-block lock bits.

Program and erase run on a behavioural job engine. The engine holds a small byte array that stands in for the flash cells. It stays busy for a fixed, parameterised number of cycles. While the engine is busy, a read drives only the top data bit, and the enable mask marks every other bit as floating.

Top module: `fcmd_ctrl`

## Requirements
- R1: After reset the read mode is array, every array byte reads FFh, no block is locked, the status byte reads 80h, and the output-enable mask is all ones.
- R2: A single write selects the read mode, and the following read uses it: FFh selects array, 90h selects identification, 98h selects query, 70h selects status.
- R3: Block erase takes two cycles: 20h, then D0h at any address in the block. No busy period begins before the D0h arrives. When the job ends, every byte of that block (64 bytes by default) reads FFh and all other blocks keep their contents.
- R4: Either 40h or 10h sets up a program. The next write's address and data start the job. When it ends, the byte holds its old value ANDed with the written data.
- R5: B0h freezes a running job. While the job is frozen, bus_oe is all ones and the status reads bit 7 set, together with bit 6 for a frozen erase or bit 2 for a frozen program. The job does not finish while frozen. D0h restarts it, and it then completes.
- R6: 60h followed by 01h sets the lock bit of the addressed block. 60h followed by D0h clears all lock bits. In identification mode, offset 2 of a block reads that block's lock bit in bit 0.
- R7: A program or erase aimed at a locked block leaves the array unchanged and starts no busy period. It sets status bit 1, plus bit 4 for a program or bit 5 for an erase.
- R8: While a job is running and not frozen, bus_oe is 80h and bus_rdata bit 7 is 0, whatever the read mode.
- R9: An erase, program or lock setup write switches the read mode to status.
- R10: An unrecognised second cycle after 20h or 60h sets status bits 5 and 4 and returns the decoder to idle, so the next write is decoded as a new command.
- R11: 50h clears status bits 5, 4 and 1.
- R12: In identification mode, offset 0 of a block reads 5Ah and offset 1 reads C3h. In query mode, offsets 0 to 2 read 51h, 52h and 59h, offset 3 reads the block count, offset 4 reads log2 of the block size, and every other offset reads 00h.
- R13: While a job is running or frozen, the setup codes 20h, 40h, 10h and 60h are ignored. Their would-be second cycle is then decoded as a plain command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | One-cycle host write strobe |
| bus_addr | input | AW | Byte address for writes and reads |
| bus_wdata | input | 8 | Write data or command byte |
| bus_rdata | output | 8 | Read data for the current address and mode |
| bus_oe | output | 8 | Per-bit output enable (0 means floating) |

## Verification
A table drives each mode-select command and then reads back identification, query, status and array addresses across several blocks. This separates the four read paths and shows that offsets are taken within a block. Directed sequences then run:
- program with both setup codes, so the AND behaviour shows up on a byte that already holds data;
- erase with a delayed confirm, which separates "waiting for confirm" from "busy";
- suspend during both job kinds, which tells the two suspend status bits apart.

Lock, bad-second-cycle and clear-error sequences then contrast the exact status byte each error path leaves behind. An array read-back after each one proves that nothing was written.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

    localparam int DW = 8;

    localparam logic [DW-1:0] OP_READ_ARRAY  = 8'hFF;
    localparam logic [DW-1:0] OP_READ_ID     = 8'h90;
    localparam logic [DW-1:0] OP_READ_QUERY  = 8'h98;
    localparam logic [DW-1:0] OP_READ_STATUS = 8'h70;
    localparam logic [DW-1:0] OP_CLR_STATUS  = 8'h50;
    localparam logic [DW-1:0] OP_ERASE_SETUP = 8'h20;
    localparam logic [DW-1:0] OP_PROG_SETUP  = 8'h40;
    localparam logic [DW-1:0] OP_PROG_ALT    = 8'h10;
    localparam logic [DW-1:0] OP_SUSPEND     = 8'hB0;
    localparam logic [DW-1:0] OP_CONFIRM     = 8'hD0;
    localparam logic [DW-1:0] OP_LOCK_SETUP  = 8'h60;
    localparam logic [DW-1:0] OP_LOCK_SET    = 8'h01;

    localparam logic [DW-1:0] MFR_CODE = 8'h5A;
    localparam logic [DW-1:0] DEV_CODE = 8'hC3;
    localparam logic [DW-1:0] QRY_C0   = 8'h51;
    localparam logic [DW-1:0] QRY_C1   = 8'h52;
    localparam logic [DW-1:0] QRY_C2   = 8'h59;

    typedef enum logic [1:0] {RM_ARRAY, RM_IDENT, RM_QUERY, RM_STATUS} rd_mode_e;
    typedef enum logic [1:0] {DS_IDLE, DS_ERASE, DS_PROG, DS_LOCK} dec_state_e;
    typedef enum logic {JOB_PROG, JOB_ERASE} job_kind_e;

    typedef struct packed {
        logic erase_err;
        logic prog_err;
        logic lock_err;
    } err_t;

    function automatic logic [DW-1:0] pack_status(input logic ready, input logic esusp,
                                                  input logic psusp, input err_t e);
        return {ready, esusp, e.erase_err, e.prog_err, 1'b0, psusp, e.lock_err, 1'b0};
    endfunction

endpackage

// File: rtl/fcmd_decoder.sv
module fcmd_decoder import fcmd_pkg::*; #(
    parameter int AW   = 8,
    parameter int OFFW = 6,
    parameter int NBLK = 1 << (AW - OFFW)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic            job_active,
    input  logic            job_susp,
    output rd_mode_e        mode,
    output err_t            err,
    output logic [NBLK-1:0] locks,
    output logic            start,
    output job_kind_e       kind,
    output logic            suspend,
    output logic            resume
);
    localparam int BW = AW - OFFW;

    dec_state_e      st_q, st_d;
    rd_mode_e        mode_d;
    err_t            err_d;
    logic [NBLK-1:0] lock_d;
    logic [BW-1:0]   blk;

    assign blk = addr[AW-1:OFFW];

    always_comb begin
        st_d    = st_q;
        mode_d  = mode;
        err_d   = err;
        lock_d  = locks;
        start   = 1'b0;
        kind    = JOB_PROG;
        suspend = 1'b0;
        resume  = 1'b0;
        if (we) begin
            case (st_q)
                DS_IDLE: begin
                    case (wdata)
                        OP_READ_ARRAY:  mode_d = RM_ARRAY;
                        OP_READ_ID:     mode_d = RM_IDENT;
                        OP_READ_QUERY:  mode_d = RM_QUERY;
                        OP_READ_STATUS: mode_d = RM_STATUS;
                        OP_CLR_STATUS:  err_d  = '0;
                        OP_ERASE_SETUP: if (!job_active) begin
                            st_d = DS_ERASE; mode_d = RM_STATUS;
                        end
                        OP_PROG_SETUP, OP_PROG_ALT: if (!job_active) begin
                            st_d = DS_PROG; mode_d = RM_STATUS;
                        end
                        OP_LOCK_SETUP: if (!job_active) begin
                            st_d = DS_LOCK; mode_d = RM_STATUS;
                        end
                        OP_SUSPEND: if (job_active && !job_susp) begin
                            suspend = 1'b1; mode_d = RM_STATUS;
                        end
                        OP_CONFIRM: if (job_susp) begin
                            resume = 1'b1; mode_d = RM_STATUS;
                        end
                        default: ;
                    endcase
                end
                DS_ERASE: begin
                    st_d = DS_IDLE;
                    if (wdata != OP_CONFIRM) begin
                        err_d.erase_err = 1'b1;
                        err_d.prog_err  = 1'b1;
                    end else if (locks[blk]) begin
                        err_d.erase_err = 1'b1;
                        err_d.lock_err  = 1'b1;
                    end else begin
                        start = 1'b1;
                        kind  = JOB_ERASE;
                    end
                end
                DS_PROG: begin
                    st_d = DS_IDLE;
                    if (locks[blk]) begin
                        err_d.prog_err = 1'b1;
                        err_d.lock_err = 1'b1;
                    end else begin
                        start = 1'b1;
                    end
                end
                default: begin
                    st_d = DS_IDLE;
                    if (wdata == OP_LOCK_SET) begin
                        lock_d[blk] = 1'b1;
                    end else if (wdata == OP_CONFIRM) begin
                        lock_d = '0;
                    end else begin
                        err_d.erase_err = 1'b1;
                        err_d.prog_err  = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= DS_IDLE;
            mode  <= RM_ARRAY;
            err   <= '0;
            locks <= '0;
        end else begin
            st_q  <= st_d;
            mode  <= mode_d;
            err   <= err_d;
            locks <= lock_d;
        end
    end

endmodule

// File: rtl/fcmd_job_engine.sv
module fcmd_job_engine import fcmd_pkg::*; #(
    parameter int AW       = 8,
    parameter int OFFW     = 6,
    parameter int BUSY_CYC = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  job_kind_e     kind,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          suspend,
    input  logic          resume,
    output logic [DW-1:0] rd_word,
    output logic          active,
    output logic          susp,
    output job_kind_e     kind_q
);
    localparam int DEPTH = 1 << AW;
    localparam int CW    = $clog2(BUSY_CYC + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] tgt_q;
    logic [DW-1:0] dat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            susp   <= 1'b0;
            kind_q <= JOB_PROG;
            cnt_q  <= '0;
            tgt_q  <= '0;
            dat_q  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (start) begin
            active <= 1'b1;
            susp   <= 1'b0;
            kind_q <= kind;
            cnt_q  <= CW'(BUSY_CYC - 1);
            tgt_q  <= addr;
            dat_q  <= wdata;
        end else if (active) begin
            if (susp) begin
                if (resume) susp <= 1'b0;
            end else if (suspend) begin
                susp <= 1'b1;
            end else if (cnt_q == '0) begin
                active <= 1'b0;
                if (kind_q == JOB_ERASE) begin
                    for (int i = 0; i < DEPTH; i++)
                        if ((i >> OFFW) == int'(tgt_q[AW-1:OFFW])) mem[i] <= '1;
                end else begin
                    mem[tgt_q] <= mem[tgt_q] & dat_q;
                end
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign rd_word = mem[addr];

endmodule

// File: rtl/fcmd_read_mux.sv
module fcmd_read_mux import fcmd_pkg::*; #(
    parameter int AW   = 8,
    parameter int OFFW = 6,
    parameter int NBLK = 1 << (AW - OFFW)
) (
    input  rd_mode_e        mode,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   arr_word,
    input  logic [NBLK-1:0] locks,
    input  err_t            err,
    input  logic            job_active,
    input  logic            job_susp,
    input  job_kind_e       job_kind,
    output logic [DW-1:0]   rdata,
    output logic [DW-1:0]   oe
);
    localparam logic [DW-1:0] BLK_CNT  = DW'(NBLK);
    localparam logic [DW-1:0] BLK_LOG2 = DW'(OFFW);

    logic [OFFW-1:0]    off;
    logic [AW-OFFW-1:0] blk;
    logic               ready;
    logic [DW-1:0]      status;

    assign off    = addr[OFFW-1:0];
    assign blk    = addr[AW-1:OFFW];
    assign ready  = !job_active || job_susp;
    assign status = pack_status(ready, job_susp && (job_kind == JOB_ERASE),
                                job_susp && (job_kind == JOB_PROG), err);

    always_comb begin
        oe    = '1;
        rdata = '0;
        if (!ready) begin
            oe = DW'(1) << (DW - 1);
        end else begin
            case (mode)
                RM_ARRAY: rdata = arr_word;
                RM_IDENT: begin
                    case (off)
                        OFFW'(0): rdata = MFR_CODE;
                        OFFW'(1): rdata = DEV_CODE;
                        OFFW'(2): rdata = DW'(locks[blk]);
                        default:  rdata = '0;
                    endcase
                end
                RM_QUERY: begin
                    case (off)
                        OFFW'(0): rdata = QRY_C0;
                        OFFW'(1): rdata = QRY_C1;
                        OFFW'(2): rdata = QRY_C2;
                        OFFW'(3): rdata = BLK_CNT;
                        OFFW'(4): rdata = BLK_LOG2;
                        default:  rdata = '0;
                    endcase
                end
                default: rdata = status;
            endcase
        end
    end

endmodule

// File: rtl/fcmd_ctrl.sv
module fcmd_ctrl import fcmd_pkg::*; #(
    parameter int AW       = 8,
    parameter int OFFW     = 6,
    parameter int BUSY_CYC = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic [DW-1:0] bus_oe
);
    localparam int NBLK = 1 << (AW - OFFW);

    rd_mode_e        dec_mode;
    err_t            dec_err;
    logic [NBLK-1:0] lock_vec;
    logic            job_start, job_susp_req, job_res_req;
    job_kind_e       job_kind, eng_kind;
    logic            eng_active, eng_susp;
    logic [DW-1:0]   arr_word;

    fcmd_decoder #(.AW(AW), .OFFW(OFFW), .NBLK(NBLK)) u_dec (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .job_active(eng_active), .job_susp(eng_susp),
        .mode(dec_mode), .err(dec_err), .locks(lock_vec),
        .start(job_start), .kind(job_kind), .suspend(job_susp_req), .resume(job_res_req)
    );

    fcmd_job_engine #(.AW(AW), .OFFW(OFFW), .BUSY_CYC(BUSY_CYC)) u_eng (
        .clk(clk), .rst(rst), .start(job_start), .kind(job_kind),
        .addr(bus_addr), .wdata(bus_wdata),
        .suspend(job_susp_req), .resume(job_res_req),
        .rd_word(arr_word), .active(eng_active), .susp(eng_susp), .kind_q(eng_kind)
    );

    fcmd_read_mux #(.AW(AW), .OFFW(OFFW), .NBLK(NBLK)) u_mux (
        .mode(dec_mode), .addr(bus_addr), .arr_word(arr_word), .locks(lock_vec),
        .err(dec_err), .job_active(eng_active), .job_susp(eng_susp), .job_kind(eng_kind),
        .rdata(bus_rdata), .oe(bus_oe)
    );

endmodule

// File: rtl/fcmd_ctrl_chk.sv
module fcmd_ctrl_chk import fcmd_pkg::*; #(
    parameter int AW   = 8,
    parameter int OFFW = 6,
    parameter int NBLK = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_we,
    input logic [DW-1:0]      bus_wdata,
    input logic [AW-OFFW-1:0] tgt_blk,
    input logic               rd_msb,
    input logic [DW-1:0]      bus_oe,
    input logic               eng_active,
    input logic               eng_susp,
    input job_kind_e          eng_kind,
    input rd_mode_e           rd_mode,
    input logic [NBLK-1:0]    lock_vec
);
    AST_ERASE_AFTER_CONFIRM: assert property (@(posedge clk) disable iff (rst)
        ($rose(eng_active) && eng_kind == JOB_ERASE) |-> ($past(bus_we) && $past(bus_wdata) == OP_CONFIRM)); // R3

    AST_SUSPEND_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        eng_susp |-> (bus_oe == '1)); // R5

    AST_NO_LOCKED_START: assert property (@(posedge clk) disable iff (rst)
        $rose(eng_active) |-> !lock_vec[$past(tgt_blk)]); // R7

    AST_BUSY_MASK: assert property (@(posedge clk) disable iff (rst)
        (eng_active && !eng_susp) |-> (bus_oe == (DW'(1) << (DW - 1)) && !rd_msb)); // R8

    AST_STATUS_ON_START: assert property (@(posedge clk) disable iff (rst)
        $rose(eng_active) |-> (rd_mode == RM_STATUS)); // R9

endmodule

bind fcmd_ctrl fcmd_ctrl_chk #(.AW(AW), .OFFW(OFFW), .NBLK(NBLK)) u_chk (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .tgt_blk(bus_addr[AW-1:OFFW]), .rd_msb(bus_rdata[DW-1]), .bus_oe(bus_oe),
    .eng_active(eng_active), .eng_susp(eng_susp), .eng_kind(eng_kind),
    .rd_mode(dec_mode), .lock_vec(lock_vec)
);

// File: tb/tb_fcmd_ctrl.sv
module tb_fcmd_ctrl;
    localparam int AW = 8;
    localparam int OFFW = 6;
    localparam int BUSY_CYC = 8;
    localparam int NVEC = 12;

    // {command, read address, expected data}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'hFF, 8'h05, 8'hFF},  // R2 array
        {8'h90, 8'h00, 8'h5A},  // R12 maker code
        {8'h90, 8'h41, 8'hC3},  // R12 device code, block 1
        {8'h90, 8'h82, 8'h00},  // R12 lock bit clear
        {8'h98, 8'h00, 8'h51},  // R12 query
        {8'h98, 8'h41, 8'h52},
        {8'h98, 8'hC2, 8'h59},
        {8'h98, 8'h03, 8'h04},  // block count
        {8'h98, 8'h44, 8'h06},  // log2 block size
        {8'h98, 8'h07, 8'h00},
        {8'h70, 8'h00, 8'h80},  // R2 status
        {8'hFF, 8'h10, 8'hFF}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, bus_oe;
    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] d, o;

    always #10 clk = ~clk;

    fcmd_ctrl #(.AW(AW), .OFFW(OFFW), .BUSY_CYC(BUSY_CYC)) dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_oe(bus_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] dv, output logic [7:0] ov);
        bus_addr = a;
        #2;
        dv = bus_rdata;
        ov = bus_oe;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: got hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);

        // R1 reset state
        rd(8'h05, d, o); chk("R1 array", d, 8'hFF); chk("R1 oe", o, 8'hFF);
        wr(8'h00, 8'h70); rd(8'h00, d, o); chk("R1 status", d, 8'h80);

        for (int i = 0; i < NVEC; i++) begin
            wr(8'h00, VEC[i][23:16]);
            rd(VEC[i][15:8], d, o);
            chk("R2/R12 table", d, VEC[i][7:0]);
        end

        // R4 program with 40h, R9 status mode, R8 mask
        wr(8'h05, 8'h40); rd(8'h05, d, o); chk("R9 status after setup", d, 8'h80);
        wr(8'h05, 8'h3C); rd(8'h05, d, o);
        chk("R8 busy oe", o, 8'h80); chk("R8 busy data", d, 8'h00);
        wr(8'h00, 8'hFF); rd(8'h05, d, o); chk("R8 mask in array mode", o, 8'h80);
        wait_cyc(BUSY_CYC + 2);
        rd(8'h05, d, o); chk("R4 oe after job", o, 8'hFF); chk("R4 programmed", d, 8'h3C);
        wr(8'h05, 8'h10); wr(8'h05, 8'hF0); wait_cyc(BUSY_CYC + 2);
        wr(8'h00, 8'hFF); rd(8'h05, d, o); chk("R4 AND with 10h", d, 8'h30);

        // R3 erase
        wr(8'h45, 8'h40); wr(8'h45, 8'h11); wait_cyc(BUSY_CYC + 2);
        wr(8'h00, 8'h20); wait_cyc(3);
        rd(8'h00, d, o); chk("R3 no start before confirm", o, 8'hFF); chk("R3 status", d, 8'h80);
        wr(8'h00, 8'hD0); rd(8'h00, d, o); chk("R3 busy after confirm", o, 8'h80);
        wait_cyc(BUSY_CYC + 2);
        wr(8'h00, 8'hFF);
        rd(8'h05, d, o); chk("R3 block erased", d, 8'hFF);
        rd(8'h45, d, o); chk("R3 other block kept", d, 8'h11);

        // R5 erase suspend, R13 setup ignored
        wr(8'h40, 8'h20); wr(8'h40, 8'hD0); wr(8'h00, 8'hB0);
        rd(8'h00, d, o); chk("R5 erase suspended status", d, 8'hC0); chk("R5 oe", o, 8'hFF);
        wait_cyc(20);
        rd(8'h00, d, o); chk("R5 still held", d, 8'hC0);
        wr(8'h00, 8'hFF); rd(8'h45, d, o); chk("R5 not erased while held", d, 8'h11);
        wr(8'h07, 8'h40); wr(8'h07, 8'h00); wr(8'h00, 8'h70);
        rd(8'h00, d, o); chk("R13 setup ignored", d, 8'hC0);
        wr(8'h00, 8'hD0); rd(8'h00, d, o); chk("R5 resumed busy", o, 8'h80);
        wait_cyc(BUSY_CYC + 2);
        wr(8'h00, 8'hFF);
        rd(8'h45, d, o); chk("R5 erase completed", d, 8'hFF);
        rd(8'h07, d, o); chk("R13 no program", d, 8'hFF);

        // R5 program suspend
        wr(8'h06, 8'h40); wr(8'h06, 8'h0F); wr(8'h00, 8'hB0);
        rd(8'h00, d, o); chk("R5 program suspended status", d, 8'h84);
        wr(8'h00, 8'hD0); wait_cyc(BUSY_CYC + 2);
        wr(8'h00, 8'hFF); rd(8'h06, d, o); chk("R5 program completed", d, 8'h0F);

        // R6 locks, R7 locked targets, R11 clear
        wr(8'h80, 8'h60); rd(8'h80, d, o); chk("R9 status after lock setup", d, 8'h80);
        wr(8'h80, 8'h01); wr(8'hC0, 8'h60); wr(8'hC0, 8'h01); wr(8'h00, 8'h90);
        rd(8'h82, d, o); chk("R6 block 2 locked", d, 8'h01);
        rd(8'hC2, d, o); chk("R6 block 3 locked", d, 8'h01);
        rd(8'h42, d, o); chk("R6 block 1 open", d, 8'h00);
        wr(8'h85, 8'h40); wr(8'h85, 8'h00);
        rd(8'h00, d, o); chk("R7 program locked status", d, 8'h92); chk("R7 no busy", o, 8'hFF);
        wr(8'h80, 8'h20); wr(8'h80, 8'hD0);
        rd(8'h00, d, o); chk("R7 erase locked status", d, 8'hB2);
        wr(8'h00, 8'hFF); rd(8'h85, d, o); chk("R7 array unchanged", d, 8'hFF);
        wr(8'h00, 8'h50); wr(8'h00, 8'h70);
        rd(8'h00, d, o); chk("R11 errors cleared", d, 8'h80);
        wr(8'h00, 8'h60); wr(8'h00, 8'hD0); wr(8'h00, 8'h90);
        rd(8'h82, d, o); chk("R6 all cleared blk2", d, 8'h00);
        rd(8'hC2, d, o); chk("R6 all cleared blk3", d, 8'h00);
        wr(8'h85, 8'h40); wr(8'h85, 8'h5A); wait_cyc(BUSY_CYC + 2);
        wr(8'h00, 8'hFF); rd(8'h85, d, o); chk("R6 program after unlock", d, 8'h5A);

        // R10 bad second cycle
        wr(8'h00, 8'h20); wr(8'h00, 8'hFF);
        rd(8'h00, d, o); chk("R10 bad erase confirm", d, 8'hB0);
        wr(8'h00, 8'h90); rd(8'h00, d, o); chk("R10 back to idle", d, 8'h5A);
        wr(8'h00, 8'h50); wr(8'h00, 8'h60); wr(8'h00, 8'h33);
        rd(8'h00, d, o); chk("R10 bad lock qualifier", d, 8'hB0);
        wr(8'h00, 8'h50); rd(8'h00, d, o); chk("R11 clear again", d, 8'h80);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule